// File: doc/BRIEF.md
# Capture/Compare Interval Timer

This block is a free-running up-counter with a small memory-mapped register bank, meant to sit on a single-clock peripheral bus. Software picks a start value, arms the timer and then gets events on overflow, on a compare match, or when an external input changes level. On each counted tick the counter advances by one. The tick comes either from every clock or from a power-of-two prescaler. When the counter passes its all-ones value it can reload from a reload register and keep going, or wrap to zero and stop itself. Software can also force a reload at any time by writing to a trigger address.

An input pin is synchronised and watched for a selectable edge. On that edge the live count is copied into a capture register. A hold mode keeps the first captured value until software acknowledges it. An output pin idles at a programmable level and reacts to overflow and match events, either with a one-clock pulse or by toggling. Three sticky event flags are masked separately onto an interrupt line and a wakeup line.

Top module: `gpt_timer`

## Requirements
- R1: After a synchronous reset the count, control, reload, compare, capture, flag and mask registers read zero, and irq, wake, evt_out and evt_oe are low.
- R2: While control bit 0 (run) is set and bit 2 (prescale enable) is clear, the count rises by one every clock. The clock edge that clears run still counts, and no later edge does.
- R3: With bit 2 set, bits 5:3 hold a select s and the count advances once every 2^(s+1) clocks. The division phase restarts from zero whenever run is clear, so the first step comes 2^(s+1) clocks after run is set.
- R4: A step from all-ones with bit 1 (auto-reload) clear leaves the count at zero, clears run, and sets flag bit 1 (overflow).
- R5: A step from all-ones with auto-reload set loads the reload register, keeps running, and sets flag bit 1.
- R6: A write to the count address loads that value. A write of any value to the trigger address loads the reload register. Both take priority over a count step on the same edge.
- R7: With bit 6 (compare enable) set, a step that lands the count on the compare register sets flag bit 0 (match). With bit 6 clear the match flag is never set.
- R8: Bits 8:7 pick the capture edge: 01 rising, 10 falling, 11 both, 00 none. The input passes a two-stage synchroniser. A selected edge copies the count into the capture register and sets flag bit 2; an unselected edge changes neither.
- R9: With bit 11 (capture hold) set, an edge that arrives while flag bit 2 is set leaves the capture register unchanged.
- R10: Writing the flag address clears each flag whose data bit is 1 and leaves the others. A new event on the same edge wins over the clear.
- R11: irq is the registered OR of the flags ANDed with the interrupt mask. wake is the same with the wakeup mask. Both are low while no flag is set.
- R12: evt_out rests at bit 9 (idle level). In pulse mode (bit 10 clear) each overflow or match event inverts it for exactly one clock. In toggle mode (bit 10 set) each event flips it and stays flipped; any control write restores the idle level. evt_oe follows bit 12.
- R13: The byte addresses are: control 0x00, count 0x04, reload 0x08, trigger 0x0C, compare 0x10, capture 0x14, flags 0x18, interrupt mask 0x1C, wakeup mask 0x20. Read data is registered, so it appears one clock after the address is presented. The trigger address reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for bus and counting |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for bus_addr |
| cap_in | input | 1 | Asynchronous capture input |
| evt_out | output | 1 | Pulse or toggle event output |
| evt_oe | output | 1 | Drive enable for the event pin |
| irq | output | 1 | Masked interrupt request |
| wake | output | 1 | Masked wakeup request |

## Verification
The hardest state to reach from the ports is an exact count after a running interval. A run started and stopped by bus writes counts a number of steps set by the write spacing, the division phase and the edge on which run falls. The bench therefore gives each random run an exact gap between the start and stop writes. A model function turns that gap and the prescale setting into the expected count. Overflows are reached by preloading values just below all-ones. Capture edges are applied while the counter is stopped, so the captured value is fully known.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

  localparam int PSEL_W = 3;
  localparam int FLG_W  = 3;

  // flag positions
  localparam int FLG_MATCH = 0;
  localparam int FLG_OVF   = 1;
  localparam int FLG_CAP   = 2;

  // register byte addresses
  localparam logic [7:0] OFS_CTRL   = 8'h00;
  localparam logic [7:0] OFS_COUNT  = 8'h04;
  localparam logic [7:0] OFS_RELOAD = 8'h08;
  localparam logic [7:0] OFS_RETRIG = 8'h0C;
  localparam logic [7:0] OFS_CMP    = 8'h10;
  localparam logic [7:0] OFS_CAPT   = 8'h14;
  localparam logic [7:0] OFS_FLAGS  = 8'h18;
  localparam logic [7:0] OFS_IEN    = 8'h1C;
  localparam logic [7:0] OFS_WEN    = 8'h20;

  // control word, bit 0 is run
  typedef struct packed {
    logic              out_drive;   // 12
    logic              cap_hold;    // 11
    logic              toggle;      // 10
    logic              idle_hi;     // 9
    logic [1:0]        edge_sel;    // 8:7
    logic              cmp_en;      // 6
    logic [PSEL_W-1:0] presc_sel;   // 5:3
    logic              presc_en;    // 2
    logic              autoreload;  // 1
    logic              run;         // 0
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/gpt_regs.sv
module gpt_regs
  import gpt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  cap_val,
  input  logic              ev_match,
  input  logic              ev_ovf,
  input  logic              ev_cap,
  input  logic              stop_req,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  reload,
  output logic [CNT_W-1:0]  cmp,
  output logic [FLG_W-1:0]  flags,
  output logic              load_en,
  output logic              trig,
  output logic              ctrl_wr,
  output logic              irq,
  output logic              wake
);

  logic [FLG_W-1:0] ien, wen, flg_set, flg_clr;
  logic wr_reload, wr_cmp, wr_flags, wr_ien, wr_wen;

  assign ctrl_wr   = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
  assign load_en   = bus_wr && (bus_addr == ADDR_W'(OFS_COUNT));
  assign wr_reload = bus_wr && (bus_addr == ADDR_W'(OFS_RELOAD));
  assign trig      = bus_wr && (bus_addr == ADDR_W'(OFS_RETRIG));
  assign wr_cmp    = bus_wr && (bus_addr == ADDR_W'(OFS_CMP));
  assign wr_flags  = bus_wr && (bus_addr == ADDR_W'(OFS_FLAGS));
  assign wr_ien    = bus_wr && (bus_addr == ADDR_W'(OFS_IEN));
  assign wr_wen    = bus_wr && (bus_addr == ADDR_W'(OFS_WEN));

  always_comb begin
    flg_set = '0;
    flg_set[FLG_MATCH] = ev_match;
    flg_set[FLG_OVF]   = ev_ovf;
    flg_set[FLG_CAP]   = ev_cap;
    flg_clr = wr_flags ? bus_wdata[FLG_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      reload <= '0;
      cmp    <= '0;
      flags  <= '0;
      ien    <= '0;
      wen    <= '0;
      irq    <= 1'b0;
      wake   <= 1'b0;
    end else begin
      if (ctrl_wr)       ctrl     <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      else if (stop_req) ctrl.run <= 1'b0;
      if (wr_reload) reload <= bus_wdata;
      if (wr_cmp)    cmp    <= bus_wdata;
      if (wr_ien)    ien    <= bus_wdata[FLG_W-1:0];
      if (wr_wen)    wen    <= bus_wdata[FLG_W-1:0];
      flags <= (flags & ~flg_clr) | flg_set;
      irq   <= |(flags & ien);
      wake  <= |(flags & wen);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      unique case (bus_addr)
        ADDR_W'(OFS_CTRL):   bus_rdata <= CNT_W'(ctrl);
        ADDR_W'(OFS_COUNT):  bus_rdata <= cnt;
        ADDR_W'(OFS_RELOAD): bus_rdata <= reload;
        ADDR_W'(OFS_CMP):    bus_rdata <= cmp;
        ADDR_W'(OFS_CAPT):   bus_rdata <= cap_val;
        ADDR_W'(OFS_FLAGS):  bus_rdata <= CNT_W'(flags);
        ADDR_W'(OFS_IEN):    bus_rdata <= CNT_W'(ien);
        ADDR_W'(OFS_WEN):    bus_rdata <= CNT_W'(wen);
        default:             bus_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/gpt_count.sv
module gpt_count
  import gpt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              autoreload,
  input  logic              presc_en,
  input  logic [PSEL_W-1:0] presc_sel,
  input  logic              cmp_en,
  input  logic [CNT_W-1:0]  cmp,
  input  logic [CNT_W-1:0]  reload,
  input  logic              load_en,
  input  logic [CNT_W-1:0]  load_val,
  input  logic              trig,
  output logic [CNT_W-1:0]  cnt,
  output logic              stop_req,
  output logic              ev_ovf,
  output logic              ev_match
);

  localparam int PDIV_W = 1 << PSEL_W;

  logic [PDIV_W-1:0] pdiv, pmask;
  logic              tick, step, wrap;
  logic [CNT_W-1:0]  nxt;

  // terminal value of the divider: 2^(sel+1)-1
  assign pmask    = {PDIV_W{1'b1}} >> (PDIV_W - 1 - int'(presc_sel));
  assign tick     = !presc_en || (pdiv == pmask);
  assign step     = run && tick && !load_en && !trig;
  assign wrap     = (cnt == {CNT_W{1'b1}});
  assign nxt      = wrap ? (autoreload ? reload : '0) : cnt + 1'b1;
  assign stop_req = step && wrap && !autoreload;

  always_ff @(posedge clk) begin
    if (rst || !run || load_en || trig || tick) pdiv <= '0;
    else                                        pdiv <= pdiv + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      ev_ovf   <= 1'b0;
      ev_match <= 1'b0;
    end else begin
      if (load_en)   cnt <= load_val;
      else if (trig) cnt <= reload;
      else if (step) cnt <= nxt;
      ev_ovf   <= step && wrap;
      ev_match <= step && cmp_en && (nxt == cmp);
    end
  end

endmodule

// File: rtl/gpt_capture.sv
module gpt_capture #(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin,
  input  logic [1:0]       edge_sel,
  input  logic             hold,
  input  logic             cap_flag,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cap_val,
  output logic             ev_cap
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync;
  logic prev, rise, fall, fire, take;

  always_ff @(posedge clk) begin
    if (rst) sync[0] <= 1'b0;
    else     sync[0] <= pin;
  end

  for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) sync[i] <= 1'b0;
      else     sync[i] <= sync[i-1];
    end
  end

  assign rise = sync[LAST] && !prev;
  assign fall = !sync[LAST] && prev;
  assign fire = (edge_sel[0] && rise) || (edge_sel[1] && fall);
  assign take = fire && !(hold && cap_flag);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev    <= 1'b0;
      cap_val <= '0;
      ev_cap  <= 1'b0;
    end else begin
      prev   <= sync[LAST];
      ev_cap <= fire;
      if (take) cap_val <= cnt;
    end
  end

endmodule

// File: rtl/gpt_outpin.sv
module gpt_outpin (
  input  logic clk,
  input  logic rst,
  input  logic idle_hi,
  input  logic toggle,
  input  logic drive,
  input  logic ctrl_wr,
  input  logic ev,
  output logic evt_out,
  output logic evt_oe
);

  logic tog, tog_nxt;

  always_comb begin
    if (ctrl_wr)  tog_nxt = 1'b0;
    else if (ev)  tog_nxt = !tog;
    else          tog_nxt = tog;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tog     <= 1'b0;
      evt_out <= 1'b0;
      evt_oe  <= 1'b0;
    end else begin
      tog     <= tog_nxt;
      evt_out <= idle_hi ^ (toggle ? tog_nxt : (ev && !ctrl_wr));
      evt_oe  <= drive;
    end
  end

endmodule

// File: rtl/gpt_timer.sv
module gpt_timer
  import gpt_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic              cap_in,
  output logic              evt_out,
  output logic              evt_oe,
  output logic              irq,
  output logic              wake
);

  ctrl_t            ctrl;
  logic [CNT_W-1:0] cnt, reload, cmp, cap_val;
  logic [FLG_W-1:0] flags;
  logic             load_en, trig, ctrl_wr, stop_req;
  logic             ev_ovf, ev_match, ev_cap;

  gpt_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt(cnt), .cap_val(cap_val),
    .ev_match(ev_match), .ev_ovf(ev_ovf), .ev_cap(ev_cap), .stop_req(stop_req),
    .ctrl(ctrl), .reload(reload), .cmp(cmp), .flags(flags),
    .load_en(load_en), .trig(trig), .ctrl_wr(ctrl_wr), .irq(irq), .wake(wake)
  );

  gpt_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst),
    .run(ctrl.run), .autoreload(ctrl.autoreload),
    .presc_en(ctrl.presc_en), .presc_sel(ctrl.presc_sel),
    .cmp_en(ctrl.cmp_en), .cmp(cmp), .reload(reload),
    .load_en(load_en), .load_val(bus_wdata), .trig(trig),
    .cnt(cnt), .stop_req(stop_req), .ev_ovf(ev_ovf), .ev_match(ev_match)
  );

  gpt_capture #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_capture (
    .clk(clk), .rst(rst), .pin(cap_in),
    .edge_sel(ctrl.edge_sel), .hold(ctrl.cap_hold), .cap_flag(flags[FLG_CAP]),
    .cnt(cnt), .cap_val(cap_val), .ev_cap(ev_cap)
  );

  gpt_outpin u_outpin (
    .clk(clk), .rst(rst),
    .idle_hi(ctrl.idle_hi), .toggle(ctrl.toggle), .drive(ctrl.out_drive),
    .ctrl_wr(ctrl_wr), .ev(ev_ovf || ev_match),
    .evt_out(evt_out), .evt_oe(evt_oe)
  );

endmodule

// File: rtl/gpt_timer_chk.sv
module gpt_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic             autoreload,
  input logic             cmp_en,
  input logic             cap_hold,
  input logic             cap_flag,
  input logic             load_en,
  input logic             trig,
  input logic             ctrl_wr,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] reload,
  input logic [CNT_W-1:0] cap_val,
  input logic             ev_ovf,
  input logic             ev_match,
  input logic [2:0]       flags,
  input logic             irq,
  input logic             wake
);

  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(run) && !$past(load_en) && !$past(trig)) |-> $stable(cnt));

  // R4 and R5: value left behind by a wrap
  assert_wrap_value_R5: assert property (@(posedge clk) disable iff (rst)
    ev_ovf |-> (cnt == ($past(autoreload) ? $past(reload) : '0)));

  assert_wrap_stops_R4: assert property (@(posedge clk) disable iff (rst)
    (ev_ovf && !$past(autoreload) && !$past(ctrl_wr)) |-> !run);

  assert_match_gated_R7: assert property (@(posedge clk) disable iff (rst)
    ev_match |-> $past(cmp_en));

  assert_capture_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    $past(cap_hold && cap_flag) |-> $stable(cap_val));

  assert_lines_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    $past(flags == 3'b000) |-> (!irq && !wake));

endmodule

bind gpt_timer gpt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst),
  .run(ctrl.run), .autoreload(ctrl.autoreload), .cmp_en(ctrl.cmp_en),
  .cap_hold(ctrl.cap_hold), .cap_flag(flags[2]),
  .load_en(load_en), .trig(trig), .ctrl_wr(ctrl_wr),
  .cnt(cnt), .reload(reload), .cap_val(cap_val),
  .ev_ovf(ev_ovf), .ev_match(ev_match), .flags(flags),
  .irq(irq), .wake(wake)
);

// File: tb/gpt_timer_test.sv
module gpt_timer_test;

  localparam logic [7:0] A_CTRL = 8'h00, A_COUNT = 8'h04, A_RELOAD = 8'h08,
                         A_RETRIG = 8'h0C, A_CMP = 8'h10, A_CAPT = 8'h14,
                         A_FLAGS = 8'h18, A_IEN = 8'h1C, A_WEN = 8'h20;
  localparam logic [31:0] C_RUN = 32'h1, C_AR = 32'h2, C_PEN = 32'h4,
                          C_CMP = 32'h40, C_IDLE = 32'h200, C_TOG = 32'h400,
                          C_HOLD = 32'h800, C_OE = 32'h1000;
  localparam logic [31:0] ALL1 = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cap_in = 1'b0;
  logic        evt_out, evt_oe, irq, wake;

  int n_cmp = 0;
  int n_bad = 0;
  int pulses = 0;

  always #2 clk = ~clk;

  gpt_timer uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in),
    .evt_out(evt_out), .evt_oe(evt_oe), .irq(irq), .wake(wake)
  );

  always @(negedge clk) if (!rst && evt_out) pulses <= pulses + 1;

  function automatic logic [31:0] model_count(input logic [31:0] v, input int span,
                                              input bit pen, input int sel);
    return v + 32'(pen ? (span >> (sel + 1)) : span);
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pin(input logic v);
    @(negedge clk);
    cap_in = v;
    idle(8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int p0;
    void'($urandom(32'd4321));
    idle(5);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    rd(A_COUNT, r);  check("R1 count", r, 0);
    rd(A_CTRL, r);   check("R1 ctrl", r, 0);
    rd(A_FLAGS, r);  check("R1 flags", r, 0);
    rd(A_CAPT, r);   check("R1 capture", r, 0);
    check("R1 pins", {28'd0, irq, wake, evt_out, evt_oe}, 0);

    // R2 plain counting and stop
    wr(A_COUNT, 100); wr(A_CTRL, C_RUN); wr(A_CTRL, 0);
    rd(A_COUNT, r); check("R2 two steps", r, 102);
    idle(6);
    rd(A_COUNT, r); check("R2 stopped holds", r, 102);

    // R3 prescaler divide by 4 over 40 clocks
    wr(A_COUNT, 0); wr(A_CTRL, C_RUN | C_PEN | (32'd1 << 3));
    idle(38); wr(A_CTRL, 0);
    rd(A_COUNT, r); check("R3 divide by 4", r, 10);

    // R2/R3 random intervals
    for (int i = 0; i < 16; i++) begin
      logic [31:0] v;
      bit pen;
      int sel, m;
      v   = $urandom & 32'h0FFF_FFFF;
      pen = 1'($urandom);
      sel = int'($urandom % 3);
      m   = int'($urandom % 60);
      wr(A_COUNT, v);
      wr(A_CTRL, C_RUN | (pen ? C_PEN : 0) | (32'(sel) << 3));
      idle(m); wr(A_CTRL, 0);
      rd(A_COUNT, r); check("R2/R3 random run", r, model_count(v, m + 2, pen, sel));
    end

    // R6 trigger and direct load
    wr(A_RELOAD, 32'h55AA); wr(A_RETRIG, 32'hDEAD);
    rd(A_COUNT, r); check("R6 trigger reload", r, 32'h55AA);
    rd(A_RETRIG, r); check("R13 trigger reads zero", r, 0);
    wr(A_CTRL, C_RUN); wr(A_COUNT, 7); wr(A_CTRL, 0);
    rd(A_COUNT, r); check("R6 load while running", r, 9);

    // R4 wrap without reload, R11 irq
    wr(A_FLAGS, 7); wr(A_IEN, 2);
    wr(A_COUNT, ALL1 - 2); wr(A_CTRL, C_RUN); idle(12);
    rd(A_COUNT, r); check("R4 wraps to zero", r, 0);
    rd(A_CTRL, r);  check("R4 run cleared", r, 0);
    rd(A_FLAGS, r); check("R4 overflow flag", r, 2);
    check("R11 irq set", {31'd0, irq}, 1);
    check("R11 wake unmasked off", {31'd0, wake}, 0);

    // R10 write-one-to-clear
    wr(A_FLAGS, 1);
    rd(A_FLAGS, r); check("R10 other bit kept", r, 2);
    wr(A_FLAGS, 2); idle(2);
    rd(A_FLAGS, r); check("R10 cleared", r, 0);
    check("R11 irq drops", {31'd0, irq}, 0);

    // R5 wrap with reload
    wr(A_RELOAD, 32'h1000); wr(A_COUNT, ALL1 - 1);
    wr(A_CTRL, C_RUN | C_AR); idle(8); wr(A_CTRL, 0);
    rd(A_COUNT, r); check("R5 reload and continue", r, 32'h1008);
    rd(A_FLAGS, r); check("R5 overflow flag", r, 2);
    wr(A_WEN, 2); idle(2);
    check("R11 wake set", {31'd0, wake}, 1);
    wr(A_FLAGS, 7); wr(A_WEN, 0); wr(A_IEN, 0);

    // R7 compare
    wr(A_COUNT, 500); wr(A_CMP, 503); wr(A_CTRL, C_RUN); idle(6); wr(A_CTRL, 0);
    rd(A_FLAGS, r); check("R7 compare disabled", r, 0);
    wr(A_COUNT, 500); wr(A_CTRL, C_RUN | C_CMP); idle(6); wr(A_CTRL, 0);
    rd(A_FLAGS, r); check("R7 match flag", r, 1);
    wr(A_FLAGS, 7); wr(A_CMP, 900);
    wr(A_COUNT, 500); wr(A_CTRL, C_RUN | C_CMP); idle(6); wr(A_CTRL, 0);
    rd(A_FLAGS, r); check("R7 unreached compare", r, 0);

    // R8 capture edges
    wr(A_CTRL, 32'd1 << 7); wr(A_COUNT, 32'h111); pin(1'b1);
    rd(A_CAPT, r);  check("R8 rising capture", r, 32'h111);
    rd(A_FLAGS, r); check("R8 capture flag", r, 4);
    wr(A_FLAGS, 7); wr(A_COUNT, 32'h222); pin(1'b0);
    rd(A_CAPT, r);  check("R8 falling ignored", r, 32'h111);
    rd(A_FLAGS, r); check("R8 no flag on falling", r, 0);
    wr(A_CTRL, 32'd2 << 7); pin(1'b1);
    rd(A_FLAGS, r); check("R8 rising ignored", r, 0);
    wr(A_COUNT, 32'h333); pin(1'b0);
    rd(A_CAPT, r);  check("R8 falling capture", r, 32'h333);
    wr(A_FLAGS, 7); wr(A_CTRL, 32'd3 << 7); wr(A_COUNT, 32'h444); pin(1'b1);
    rd(A_CAPT, r);  check("R8 both edges", r, 32'h444);
    wr(A_FLAGS, 7); wr(A_CTRL, 0); wr(A_COUNT, 32'h555); pin(1'b0);
    rd(A_CAPT, r);  check("R8 capture off", r, 32'h444);
    rd(A_FLAGS, r); check("R8 off no flag", r, 0);

    // R9 hold mode
    wr(A_CTRL, (32'd3 << 7) | C_HOLD); wr(A_COUNT, 32'h666); pin(1'b1);
    rd(A_CAPT, r);  check("R9 first capture", r, 32'h666);
    wr(A_COUNT, 32'h777); pin(1'b0);
    rd(A_CAPT, r);  check("R9 held value", r, 32'h666);
    rd(A_FLAGS, r); check("R9 flag stays", r, 4);
    wr(A_FLAGS, 7); wr(A_COUNT, 32'h888); pin(1'b1);
    rd(A_CAPT, r);  check("R9 after ack", r, 32'h888);

    // R12 output pin
    wr(A_FLAGS, 7); wr(A_CTRL, C_OE); idle(2);
    check("R12 drive and idle", {30'd0, evt_oe, evt_out}, 2'b10);
    wr(A_COUNT, ALL1 - 4); wr(A_CMP, ALL1 - 2);
    p0 = pulses;
    wr(A_CTRL, C_RUN | C_CMP | C_OE); idle(16);
    check("R12 pulse count", 32'(pulses - p0), 2);
    check("R12 back to idle", {31'd0, evt_out}, 0);
    wr(A_COUNT, ALL1 - 1); wr(A_CTRL, C_RUN | C_TOG | C_OE); idle(10);
    check("R12 toggled", {31'd0, evt_out}, 1);
    wr(A_CTRL, C_TOG | C_OE); idle(2);
    check("R12 toggle reset", {31'd0, evt_out}, 0);
    wr(A_CTRL, C_IDLE); idle(2);
    check("R12 idle high", {30'd0, evt_oe, evt_out}, 2'b01);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule